// File: doc/BRIEF.md
# HI/LO Multiply-Divide-Accumulate Unit

This block is the multiply/divide companion of a 32-bit integer pipeline. It owns the HI and LO result registers. It runs multiplies and divides on two 32-bit source operands, named rs and rt, in signed and unsigned forms. It can also add a product into the 64-bit HI:LO pair or subtract a product from it. There is one more multiply form that returns only the low word of a signed product, for the destination register rd.

The pipeline presents an operation as a one-cycle `start` pulse. The pulse carries a 6-bit function code and a flag that selects the secondary opcode group. Multi-cycle operations raise `busy` until they finish. A read of HI or LO comes back as a one-cycle `rd_valid` pulse on `rd_data`. The pipeline can issue a read while the unit is busy. The unit then keeps that read and delivers it once the running operation has written its result.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `rd_data` are 0, and HI and LO both read back as 0.
- R2: With `sel_special2`=0, the function codes are 0x10 (read HI), 0x11 (write HI from rs), 0x12 (read LO) and 0x13 (write LO from rs). A write takes effect at the start edge. A read gives `rd_valid`=1 with the register value in the cycle after the start edge. Neither a read nor a write raises `busy`.
- R3: With `sel_special2`=0, codes 0x18 (signed) and 0x19 (unsigned) multiply rs by rt. The upper word of the 64-bit product goes to HI and the lower word to LO. `busy` is high for exactly MUL_LAT cycles, starting in the cycle after the start edge.
- R4: With `sel_special2`=1, codes 0x00 (signed) and 0x01 (unsigned) add the 64-bit product of rs and rt to HI:LO, modulo 2^64. The busy timing is the same as in R3.
- R5: With `sel_special2`=1, codes 0x04 (signed) and 0x05 (unsigned) subtract the 64-bit product from HI:LO, modulo 2^64. The busy timing is the same as in R3.
- R6: With `sel_special2`=1, code 0x02 forms the signed product. `rd_valid` pulses with the product's low 32 bits in the first cycle in which `busy` is low again. HI and LO keep their values.
- R7: With `sel_special2`=0, codes 0x1A (signed) and 0x1B (unsigned) divide rs by rt. The remainder goes to HI and the quotient to LO. A signed quotient is truncated toward zero, and a nonzero signed remainder has the sign of the dividend. `busy` is high for exactly DIV_STEPS+1 cycles.
- R8: A divide by zero takes the same DIV_STEPS+1 busy cycles as any other divide and then returns to idle.
- R9: A read of HI or LO issued while `busy` is high is held. Its `rd_valid` pulse carries the value written by the running operation. `busy` stays high one extra cycle and falls in the same cycle as `rd_valid` rises.
- R10: Any other start pulse while `busy` is high has no effect. This includes a write to HI or LO. A start with a function code not listed above also has no effect: it raises neither `busy` nor `rd_valid`, and it changes neither HI nor LO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse |
| sel_special2 | input | 1 | 1 selects the secondary opcode group for `funct` |
| funct | input | 6 | Function code of the request |
| rs_val | input | W | First operand; also the source of writes to HI and LO |
| rt_val | input | W | Second operand |
| busy | output | 1 | High while an operation or a held read is pending |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` is valid |
| rd_data | output | W | Value read from HI or LO, or the low word of the 32-bit-result multiply |

## Verification
A fault in the divider's step counter or shift datapath shows at the ports as a wrong `busy` length and wrong HI/LO values. Both show up when HI and LO are next read, at most DIV_STEPS+2 cycles after the start pulse. A wrong operation kind or signedness latched at the start pulse corrupts HI:LO at the completing edge, so the read that follows exposes it. Signed-negative operand patterns and accumulate sequences tell this case apart from the unsigned one. A lost or stale held read shows as a missing `rd_valid` pulse or as pre-operation data when `busy` falls. A leaked write during `busy` shows in the next read of HI.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

    // Function codes, primary group (sel_special2 = 0)
    localparam logic [5:0] F_RD_HI   = 6'h10;
    localparam logic [5:0] F_WR_HI   = 6'h11;
    localparam logic [5:0] F_RD_LO   = 6'h12;
    localparam logic [5:0] F_WR_LO   = 6'h13;
    localparam logic [5:0] F_MUL_S   = 6'h18;
    localparam logic [5:0] F_MUL_U   = 6'h19;
    localparam logic [5:0] F_DIV_S   = 6'h1A;
    localparam logic [5:0] F_DIV_U   = 6'h1B;

    // Function codes, secondary group (sel_special2 = 1)
    localparam logic [5:0] G_ACC_S   = 6'h00;
    localparam logic [5:0] G_ACC_U   = 6'h01;
    localparam logic [5:0] G_MUL32   = 6'h02;
    localparam logic [5:0] G_DEC_S   = 6'h04;
    localparam logic [5:0] G_DEC_U   = 6'h05;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_MULT  = 3'd1,
        K_ACC   = 3'd2,
        K_DEC   = 3'd3,
        K_MUL32 = 3'd4,
        K_DIV   = 3'd5
    } op_kind_e;

endpackage

// File: rtl/hilo_mult.sv
module hilo_mult #(
    parameter int W   = 32,
    parameter int LAT = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_i,
    input  logic           sgn_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o,
    output logic           done_o
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic [LAT-1:0]         vld;
        logic [LAT-1:0][PW-1:0] prod;
    } mul_st_t;

    mul_st_t st_d, st_q;

    logic [PW-1:0] a_ext, b_ext, prod_now;

    always_comb begin
        // sign- or zero-extend to full width; low PW bits of the product are exact
        a_ext    = {{W{sgn_i & a_i[W-1]}}, a_i};
        b_ext    = {{W{sgn_i & b_i[W-1]}}, b_i};
        prod_now = a_ext * b_ext;

        st_d         = st_q;
        st_d.vld[0]  = go_i;
        st_d.prod[0] = prod_now;
        for (int i = 1; i < LAT; i++) begin
            st_d.vld[i]  = st_q.vld[i-1];
            st_d.prod[i] = st_q.prod[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prod_o = st_q.prod[LAT-1];
    assign done_o = st_q.vld[LAT-1];

    AST_MUL_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.vld)); // R3

endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic         sgn_i,
    input  logic [W-1:0] n_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         done_o
);
    localparam int CW = $clog2(W + 1);
    localparam logic [CW-1:0] LAST = CW'(W);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          neg_q;
        logic          neg_r;
    } div_st_t;

    div_st_t st_d, st_q;

    logic [W:0] shifted, trial;

    always_comb begin
        shifted = {st_q.rem, st_q.quo[W-1]};
        trial   = shifted - {1'b0, st_q.dvs};
        st_d    = st_q;
        if (go_i) begin
            st_d.run   = 1'b1;
            st_d.cnt   = '0;
            st_d.rem   = '0;
            st_d.quo   = (sgn_i && n_i[W-1]) ? -n_i : n_i;
            st_d.dvs   = (sgn_i && d_i[W-1]) ? -d_i : d_i;
            st_d.neg_q = sgn_i & (n_i[W-1] ^ d_i[W-1]);
            st_d.neg_r = sgn_i & n_i[W-1];
        end else if (st_q.run) begin
            if (st_q.cnt == LAST) begin
                st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                if (!trial[W]) begin
                    st_d.rem = trial[W-1:0];
                    st_d.quo = {st_q.quo[W-2:0], 1'b1};
                end else begin
                    st_d.rem = shifted[W-1:0];
                    st_d.quo = {st_q.quo[W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.run && (st_q.cnt == LAST);
    assign quo_o  = st_q.neg_q ? -st_q.quo : st_q.quo;
    assign rem_o  = st_q.neg_r ? -st_q.rem : st_q.rem;

    AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt <= LAST)); // R7
    AST_DIV_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && !done_o && !go_i) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1)); // R7

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit #(
    parameter int W       = 32,
    parameter int MUL_LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sel_special2,
    input  logic [5:0]   funct,
    input  logic [W-1:0] rs_val,
    input  logic [W-1:0] rt_val,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    import hilo_pkg::*;

    localparam int PW = 2 * W;

    typedef struct packed {
        logic [W-1:0] hi;
        logic [W-1:0] lo;
        logic         busy;
        op_kind_e     kind;
        logic         pend;
        logic         pend_hi;
        logic         rdv;
        logic [W-1:0] rdd;
    } top_st_t;

    top_st_t st_d, st_q;

    logic          mul_go, mul_sgn, mul_done;
    logic [PW-1:0] mul_prod;
    logic          div_go, div_sgn, div_done;
    logic [W-1:0]  div_quo, div_rem;
    logic          is_read, read_hi;
    logic [PW-1:0] pair_now;

    hilo_mult #(.W(W), .LAT(MUL_LAT)) u_mult (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (mul_go),
        .sgn_i  (mul_sgn),
        .a_i    (rs_val),
        .b_i    (rt_val),
        .prod_o (mul_prod),
        .done_o (mul_done)
    );

    hilo_div #(.W(W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (div_go),
        .sgn_i  (div_sgn),
        .n_i    (rs_val),
        .d_i    (rt_val),
        .quo_o  (div_quo),
        .rem_o  (div_rem),
        .done_o (div_done)
    );

    always_comb begin
        is_read  = !sel_special2 && ((funct == F_RD_HI) || (funct == F_RD_LO));
        read_hi  = (funct == F_RD_HI);
        pair_now = {st_q.hi, st_q.lo};

        st_d     = st_q;
        st_d.rdv = 1'b0;
        mul_go   = 1'b0;
        mul_sgn  = 1'b0;
        div_go   = 1'b0;
        div_sgn  = 1'b0;

        if (st_q.busy) begin
            // only a read may be queued behind a running operation
            if (start && is_read && !st_q.pend) begin
                st_d.pend    = 1'b1;
                st_d.pend_hi = read_hi;
            end
            if (mul_done) begin
                st_d.busy = 1'b0;
                case (st_q.kind)
                    K_MULT:  {st_d.hi, st_d.lo} = mul_prod;
                    K_ACC:   {st_d.hi, st_d.lo} = pair_now + mul_prod;
                    K_DEC:   {st_d.hi, st_d.lo} = pair_now - mul_prod;
                    K_MUL32: begin
                        st_d.rdv = 1'b1;
                        st_d.rdd = mul_prod[W-1:0];
                    end
                    default: ;
                endcase
            end
            if (div_done) begin
                st_d.busy = 1'b0;
                st_d.hi   = div_rem;
                st_d.lo   = div_quo;
            end
        end else if (st_q.pend) begin
            st_d.pend = 1'b0;
            st_d.rdv  = 1'b1;
            st_d.rdd  = st_q.pend_hi ? st_q.hi : st_q.lo;
        end else if (start) begin
            if (!sel_special2) begin
                case (funct)
                    F_RD_HI: begin st_d.rdv = 1'b1; st_d.rdd = st_q.hi; end
                    F_RD_LO: begin st_d.rdv = 1'b1; st_d.rdd = st_q.lo; end
                    F_WR_HI: st_d.hi = rs_val;
                    F_WR_LO: st_d.lo = rs_val;
                    F_MUL_S, F_MUL_U: begin
                        mul_go    = 1'b1;
                        mul_sgn   = (funct == F_MUL_S);
                        st_d.busy = 1'b1;
                        st_d.kind = K_MULT;
                    end
                    F_DIV_S, F_DIV_U: begin
                        div_go    = 1'b1;
                        div_sgn   = (funct == F_DIV_S);
                        st_d.busy = 1'b1;
                        st_d.kind = K_DIV;
                    end
                    default: ;
                endcase
            end else begin
                case (funct)
                    G_ACC_S, G_ACC_U: begin
                        mul_go    = 1'b1;
                        mul_sgn   = (funct == G_ACC_S);
                        st_d.busy = 1'b1;
                        st_d.kind = K_ACC;
                    end
                    G_DEC_S, G_DEC_U: begin
                        mul_go    = 1'b1;
                        mul_sgn   = (funct == G_DEC_S);
                        st_d.busy = 1'b1;
                        st_d.kind = K_DEC;
                    end
                    G_MUL32: begin
                        mul_go    = 1'b1;
                        mul_sgn   = 1'b1;
                        st_d.busy = 1'b1;
                        st_d.kind = K_MUL32;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.kind <= K_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy | st_q.pend;
    assign rd_valid = st_q.rdv;
    assign rd_data  = st_q.rdd;

    AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.busy) |-> $past(mul_done || div_done)); // R3
    AST_DONE_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_done || div_done) |-> st_q.busy); // R7
    AST_HOLD_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.pend) |-> $past(st_q.busy)); // R9
    AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !mul_done && !div_done) |=> ($stable(st_q.hi) && $stable(st_q.lo))); // R10

endmodule

// File: tb/test_hilo_muldiv_unit.sv
module test_hilo_muldiv_unit;
    localparam int W       = 32;
    localparam int MUL_LAT = 2;
    localparam int DIV_BUSY = W + 1;
    localparam int NV = 13;

    // {group, funct, rs, rt}
    localparam logic [70:0] VEC [NV] = '{
        {1'b0, 6'h18, 32'h0000_1234, 32'h0000_5678},
        {1'b0, 6'h18, 32'hFFFF_FFFD, 32'h0000_0007},
        {1'b0, 6'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b0, 6'h18, 32'h8000_0000, 32'h8000_0000},
        {1'b1, 6'h00, 32'h0000_0010, 32'hFFFF_FFFF},
        {1'b1, 6'h01, 32'hFFFF_FFFF, 32'h0000_0002},
        {1'b1, 6'h04, 32'h0000_0003, 32'hFFFF_FFFB},
        {1'b1, 6'h05, 32'h1000_0000, 32'h0000_0100},
        {1'b0, 6'h1A, 32'hFFFF_FFF9, 32'h0000_0002},
        {1'b0, 6'h1A, 32'h0000_0007, 32'hFFFF_FFFE},
        {1'b0, 6'h1B, 32'hFFFF_FFF9, 32'h0000_0002},
        {1'b0, 6'h1A, 32'h8000_0000, 32'h0000_0003},
        {1'b0, 6'h1B, 32'h0000_0005, 32'h0000_0009}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         sp2 = 1'b0;
    logic [5:0]   funct = '0;
    logic [W-1:0] rs = '0, rt = '0;
    logic         busy, rd_valid;
    logic [W-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] mdl_hi = '0, mdl_lo = '0;

    always #2 clk = ~clk;

    hilo_muldiv_unit #(.W(W), .MUL_LAT(MUL_LAT)) i_hilo_muldiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .sel_special2(sp2),
        .funct(funct), .rs_val(rs), .rt_val(rt),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic g, input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
        @(negedge clk);
        sp2 = g; funct = f; rs = a; rt = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle(output int cnt);
        cnt = 0;
        while (busy) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic read_reg(input logic hi, output logic v, output logic [W-1:0] val);
        issue(1'b0, hi ? 6'h10 : 6'h12, '0, '0);
        v = rd_valid;
        val = rd_data;
    endtask

    task automatic model(input logic g, input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [63:0] ps, pu, pair;
        int sa, sb;
        ps   = longint'(signed'(a)) * longint'(signed'(b));
        pu   = {32'h0, a} * {32'h0, b};
        pair = {mdl_hi, mdl_lo};
        sa = a; sb = b;
        if (!g) begin
            case (f)
                6'h18: {mdl_hi, mdl_lo} = ps;
                6'h19: {mdl_hi, mdl_lo} = pu;
                6'h1A: begin mdl_lo = sa / sb; mdl_hi = sa % sb; end
                6'h1B: begin mdl_lo = a / b; mdl_hi = a % b; end
                default: ;
            endcase
        end else begin
            case (f)
                6'h00: {mdl_hi, mdl_lo} = pair + ps;
                6'h01: {mdl_hi, mdl_lo} = pair + pu;
                6'h04: {mdl_hi, mdl_lo} = pair - ps;
                6'h05: {mdl_hi, mdl_lo} = pair - pu;
                default: ;
            endcase
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog all-requirements actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic v;
        logic [W-1:0] val;
        int cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "busy", W'(busy), 0);
        chk("R1", "rd_valid", W'(rd_valid), 0);
        chk("R1", "rd_data", rd_data, 0);
        read_reg(1'b1, v, val);
        chk("R1", "hi", val, 0);
        read_reg(1'b0, v, val);
        chk("R1", "lo", val, 0);

        // R2: direct writes and reads
        issue(1'b0, 6'h11, 32'hCAFE_0001, '0);
        chk("R2", "busy after write", W'(busy), 0);
        issue(1'b0, 6'h13, 32'h0BAD_F00D, '0);
        read_reg(1'b1, v, val);
        chk("R2", "read valid", W'(v), 1);
        chk("R2", "hi", val, 32'hCAFE_0001);
        read_reg(1'b0, v, val);
        chk("R2", "lo", val, 32'h0BAD_F00D);
        mdl_hi = 32'hCAFE_0001;
        mdl_lo = 32'h0BAD_F00D;

        // R3 R4 R5 R7: vector table
        for (int i = 0; i < NV; i++) begin
            logic g;
            logic [5:0] f;
            logic [W-1:0] a, b;
            string req;
            int exp_busy;
            {g, f, a, b} = VEC[i];
            if (!g && (f == 6'h1A || f == 6'h1B)) begin req = "R7"; exp_busy = DIV_BUSY; end
            else if (!g) begin req = "R3"; exp_busy = MUL_LAT; end
            else if (f == 6'h00 || f == 6'h01) begin req = "R4"; exp_busy = MUL_LAT; end
            else begin req = "R5"; exp_busy = MUL_LAT; end
            issue(g, f, a, b);
            wait_idle(cnt);
            model(g, f, a, b);
            chk(req, "busy cycles", W'(cnt), W'(exp_busy));
            read_reg(1'b1, v, val);
            chk(req, "hi", val, mdl_hi);
            read_reg(1'b0, v, val);
            chk(req, "lo", val, mdl_lo);
        end

        // R6: low-word signed multiply leaves HI/LO untouched
        issue(1'b0, 6'h11, 32'h1111_1111, '0);
        issue(1'b0, 6'h13, 32'h2222_2222, '0);
        issue(1'b1, 6'h02, 32'hFFFF_FFFD, 32'h0000_0007);
        wait_idle(cnt);
        chk("R6", "busy cycles", W'(cnt), W'(MUL_LAT));
        chk("R6", "rd_valid", W'(rd_valid), 1);
        chk("R6", "rd_data", rd_data, 32'hFFFF_FFEB);
        read_reg(1'b1, v, val);
        chk("R6", "hi kept", val, 32'h1111_1111);
        read_reg(1'b0, v, val);
        chk("R6", "lo kept", val, 32'h2222_2222);

        // R8: divide by zero completes
        issue(1'b0, 6'h1A, 32'h0000_0005, 32'h0);
        wait_idle(cnt);
        chk("R8", "signed busy cycles", W'(cnt), W'(DIV_BUSY));
        issue(1'b0, 6'h1B, 32'hFFFF_0000, 32'h0);
        wait_idle(cnt);
        chk("R8", "unsigned busy cycles", W'(cnt), W'(DIV_BUSY));

        // R9: read held behind a divide (100/7 -> r 2, q 14)
        issue(1'b0, 6'h1A, 32'd100, 32'd7);
        sp2 = 1'b0; funct = 6'h10; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(cnt);
        chk("R9", "busy cycles", W'(cnt + 1), W'(DIV_BUSY + 1));
        chk("R9", "rd_valid", W'(rd_valid), 1);
        chk("R9", "rd_data", rd_data, 32'd2);

        // R10: write during busy ignored; unknown code ignored
        issue(1'b0, 6'h18, 32'd3, 32'd4);
        sp2 = 1'b0; funct = 6'h11; rs = 32'hDEAD_BEEF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(cnt);
        read_reg(1'b1, v, val);
        chk("R10", "hi after blocked write", val, 32'h0);
        read_reg(1'b0, v, val);
        chk("R10", "lo", val, 32'd12);
        issue(1'b0, 6'h3F, 32'h5555_5555, 32'h1);
        chk("R10", "unknown busy", W'(busy), 0);
        chk("R10", "unknown rd_valid", W'(rd_valid), 0);
        read_reg(1'b1, v, val);
        chk("R10", "hi after unknown", val, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule